// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a tag-to-reader frame of known length from a digitised subcarrier line. Once the reader frame has ended, the controller issues a request and the receiver waits a fixed turnaround time. It then splits the following time into equal bit windows that run back to back with no gap. In each window it counts level changes on the synchronised input. A window that holds a full subcarrier burst shows many transitions and decodes as a one. A quiet window decodes as a zero. The decoded bits are XORed with a keystream word that is supplied along with the request, and the de-whitened word is returned.

A second mode searches for an acknowledge burst. It examines up to a fixed number of windows and stops at the first window whose transition count lies inside an acceptance band. It then reports success and the number of windows that have elapsed. If no window qualifies, it reports failure once the last window has closed.

Requests use a valid/ready handshake. `req_ready` is high only while the receiver is idle, and a request is taken on any cycle where both `req_valid` and `req_ready` are high. The result port has no back-pressure. `res_valid` is a one-cycle strobe, and the result fields hold their values until the next result, so the consumer must take the result in the strobe cycle or read the held fields before it issues another request.

Top module: `sc_edge_rx`

## Requirements
- R1: After reset `req_ready` is 1, and `res_valid`, `res_word` and `ack_found` are 0. `req_ready` is 1 exactly while idle. An accepted request that is not rejected drops `req_ready` in the next cycle, and `req_ready` stays low until the result.
- R2: A decode request (`req_ack_mode`=0) with `req_bits` equal to 0 or greater than MAX_BITS is rejected. `res_valid` and `res_reject` are 1 in the cycle after acceptance, with `res_word`=0 and `ack_found`=0.
- R3: Input transitions during the TURN_TICKS cycles after acceptance are not counted in any window.
- R4: Windows of WIN_TICKS cycles each follow the turnaround with no gap. A result after N windows has `res_valid` high in the cycle that starts TURN_TICKS + N*WIN_TICKS clock edges after the accepting edge, and never earlier.
- R5: Every change of the synchronised input level inside a window counts as one transition. A window with more than ONE_THRESH (20) transitions decodes as 1, and otherwise as 0.
- R6: Decoded bit i (window i, counting from 0) sits at bit position i of `res_word`. `res_word` = keystream XOR decoded bits for positions below `req_bits`, and the bits at and above `req_bits` are 0.
- R7: The per-window transition count saturates at 63 and does not wrap. For example, 70 transitions still decode as 1, and 90 transitions fall outside the acknowledge band.
- R8: In acknowledge mode the first window whose count is strictly greater than 20 and strictly less than ACK_HI (60) ends the search. The result then has `ack_found`=1, `ack_windows` = index of that window + 1 and `res_word`=0, and it arrives at the end of that window.
- R9: If none of ACK_MAX_WIN (80) windows qualifies, the result has `ack_found`=0 and `ack_windows`=ACK_MAX_WIN.
- R10: In acknowledge mode `req_bits` is ignored, so a value of 0 does not cause a rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Receiver idle, request can be taken |
| req_ack_mode | input | 1 | 1 = acknowledge search, 0 = frame decode |
| req_bits | input | BITS_W | Frame length in bits for decode mode |
| req_key | input | MAX_BITS | Keystream word, LSB applies to the first bit |
| sc_in | input | 1 | Digitised subcarrier line (asynchronous) |
| res_valid | output | 1 | One-cycle result strobe |
| res_reject | output | 1 | Request was rejected |
| res_word | output | MAX_BITS | De-whitened decoded word |
| ack_found | output | 1 | Acknowledge burst seen |
| ack_windows | output | AW_W | Windows elapsed in acknowledge search |

## Verification
The bench shortens the timing to TURN_TICKS=40 and WIN_TICKS=120 and keeps MAX_BITS=32 and ACK_MAX_WIN=80. A window of 120 cycles is long enough for the bench to place up to 100 transitions in one window, which drives the counter into saturation and exposes any wraparound. A full 80-window search that fails still takes under ten thousand cycles, so it fits in the run several times over. Transitions are placed well clear of window boundaries to allow for the synchroniser delay, and the result cycle is compared against the exact expected edge count.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_WIN  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_pulse
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] shr;
  logic             last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr    <= '0;
      last_q <= 1'b0;
    end else begin
      shr    <= {shr[DEPTH-2:0], din};
      last_q <= shr[DEPTH-1];
    end
  end

  assign edge_pulse = shr[DEPTH-1] ^ last_q;
endmodule

// File: rtl/sc_rx_window.sv
module sc_rx_window #(
  parameter int WIN_TICKS = 150,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             edge_in,
  output logic             win_end,
  output logic [CNT_W-1:0] win_total
);
  localparam int TICK_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(WIN_TICKS - 1);
  localparam logic [CNT_W-1:0]  CNT_TOP   = '1;

  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  cnt_q;

  assign win_total = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_W'(edge_in);
  assign win_end   = run && (tick_q == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (!run) begin
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (win_end) begin
      tick_q <= '0;
      cnt_q  <= '0;
    end else begin
      tick_q <= tick_q + TICK_W'(1);
      cnt_q  <= win_total;
    end
  end
endmodule

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
  import sc_rx_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int ACK_MAX_WIN = 80,
  parameter int TURN_TICKS  = 495,
  parameter int ONE_THRESH  = 20,
  parameter int ACK_HI      = 60,
  parameter int CNT_W       = 6,
  parameter int BITS_W      = 7,
  parameter int AW_W        = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_ack_mode,
  input  logic [BITS_W-1:0]   req_bits,
  input  logic [MAX_BITS-1:0] req_key,
  input  logic                win_end,
  input  logic [CNT_W-1:0]    win_total,
  output logic                win_run,
  output logic                res_valid,
  output logic                res_reject,
  output logic [MAX_BITS-1:0] res_word,
  output logic                ack_found,
  output logic [AW_W-1:0]     ack_windows
);
  localparam int SPAN   = (MAX_BITS > ACK_MAX_WIN) ? MAX_BITS : ACK_MAX_WIN;
  localparam int IDX_W  = $clog2(SPAN + 1);
  localparam int TURN_W = (TURN_TICKS > 1) ? $clog2(TURN_TICKS) : 1;

  localparam logic [TURN_W-1:0] TURN_LAST = TURN_W'(TURN_TICKS - 1);
  localparam logic [CNT_W-1:0]  ONE_T     = CNT_W'(ONE_THRESH);
  localparam logic [CNT_W-1:0]  ACK_T     = CNT_W'(ACK_HI);
  localparam logic [IDX_W-1:0]  ACK_LAST  = IDX_W'(ACK_MAX_WIN - 1);
  localparam logic [BITS_W-1:0] BITS_TOP  = BITS_W'(MAX_BITS);

  rx_state_e             state_q;
  logic [TURN_W-1:0]     tcnt_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      nbits_q;
  logic                  mode_q;
  logic [MAX_BITS-1:0]   word_q;

  logic                  take;
  logic                  bad_req;
  logic                  bit_one;
  logic                  ack_hit;
  logic [MAX_BITS-1:0]   word_nx;

  function automatic logic [MAX_BITS-1:0] low_mask(input logic [BITS_W-1:0] n);
    logic [MAX_BITS-1:0] m;
    for (int i = 0; i < MAX_BITS; i++) begin
      m[i] = (i < int'(n));
    end
    return m;
  endfunction

  assign req_ready = (state_q == ST_IDLE);
  assign win_run   = (state_q == ST_WIN);
  assign take      = req_valid && req_ready;
  assign bad_req   = !req_ack_mode && ((req_bits == '0) || (req_bits > BITS_TOP));
  assign bit_one   = (win_total > ONE_T);
  assign ack_hit   = (win_total > ONE_T) && (win_total < ACK_T);
  assign word_nx   = word_q ^ ({{(MAX_BITS-1){1'b0}}, bit_one} << idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tcnt_q      <= '0;
      idx_q       <= '0;
      nbits_q     <= '0;
      mode_q      <= 1'b0;
      word_q      <= '0;
      res_valid   <= 1'b0;
      res_reject  <= 1'b0;
      res_word    <= '0;
      ack_found   <= 1'b0;
      ack_windows <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            if (bad_req) begin
              res_valid   <= 1'b1;
              res_reject  <= 1'b1;
              res_word    <= '0;
              ack_found   <= 1'b0;
              ack_windows <= '0;
            end else begin
              state_q <= ST_TURN;
              tcnt_q  <= '0;
              idx_q   <= '0;
              mode_q  <= req_ack_mode;
              nbits_q <= IDX_W'(req_bits);
              word_q  <= req_ack_mode ? '0 : (req_key & low_mask(req_bits));
            end
          end
        end
        ST_TURN: begin
          if (tcnt_q == TURN_LAST) state_q <= ST_WIN;
          else                     tcnt_q  <= tcnt_q + TURN_W'(1);
        end
        ST_WIN: begin
          if (win_end) begin
            if (mode_q) begin
              if (ack_hit || (idx_q == ACK_LAST)) begin
                state_q     <= ST_IDLE;
                res_valid   <= 1'b1;
                res_reject  <= 1'b0;
                res_word    <= '0;
                ack_found   <= ack_hit;
                ack_windows <= AW_W'(idx_q + IDX_W'(1));
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
            end else begin
              if (idx_q == nbits_q - IDX_W'(1)) begin
                state_q     <= ST_IDLE;
                res_valid   <= 1'b1;
                res_reject  <= 1'b0;
                res_word    <= word_nx;
                ack_found   <= 1'b0;
                ack_windows <= '0;
              end else begin
                word_q <= word_nx;
                idx_q  <= idx_q + IDX_W'(1);
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx #(
  parameter int MAX_BITS    = 32,
  parameter int ACK_MAX_WIN = 80,
  parameter int TURN_TICKS  = 495,
  parameter int WIN_TICKS   = 150,
  parameter int ONE_THRESH  = 20,
  parameter int ACK_HI      = 60,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int BITS_W      = $clog2(MAX_BITS + 1) + 1,
  parameter int AW_W        = $clog2(ACK_MAX_WIN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_ack_mode,
  input  logic [BITS_W-1:0]   req_bits,
  input  logic [MAX_BITS-1:0] req_key,
  input  logic                sc_in,
  output logic                res_valid,
  output logic                res_reject,
  output logic [MAX_BITS-1:0] res_word,
  output logic                ack_found,
  output logic [AW_W-1:0]     ack_windows
);
  logic             edge_pulse;
  logic             win_run;
  logic             win_end;
  logic [CNT_W-1:0] win_total;

  sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (sc_in),
    .edge_pulse (edge_pulse)
  );

  sc_rx_window #(.WIN_TICKS(WIN_TICKS), .CNT_W(CNT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (win_run),
    .edge_in   (edge_pulse),
    .win_end   (win_end),
    .win_total (win_total)
  );

  sc_rx_ctrl #(
    .MAX_BITS    (MAX_BITS),
    .ACK_MAX_WIN (ACK_MAX_WIN),
    .TURN_TICKS  (TURN_TICKS),
    .ONE_THRESH  (ONE_THRESH),
    .ACK_HI      (ACK_HI),
    .CNT_W       (CNT_W),
    .BITS_W      (BITS_W),
    .AW_W        (AW_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_ack_mode (req_ack_mode),
    .req_bits     (req_bits),
    .req_key      (req_key),
    .win_end      (win_end),
    .win_total    (win_total),
    .win_run      (win_run),
    .res_valid    (res_valid),
    .res_reject   (res_reject),
    .res_word     (res_word),
    .ack_found    (ack_found),
    .ack_windows  (ack_windows)
  );
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk #(
  parameter int MAX_BITS    = 32,
  parameter int ACK_MAX_WIN = 80,
  parameter int BITS_W      = 7,
  parameter int AW_W        = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_ack_mode,
  input logic [BITS_W-1:0]   req_bits,
  input logic                res_valid,
  input logic                res_reject,
  input logic [MAX_BITS-1:0] res_word,
  input logic                ack_found,
  input logic [AW_W-1:0]     ack_windows
);
  localparam logic [BITS_W-1:0] BTOP = BITS_W'(MAX_BITS);
  localparam logic [AW_W-1:0]   ATOP = AW_W'(ACK_MAX_WIN);

  logic good_take;
  logic bad_take;
  assign good_take = req_valid && req_ready &&
                     (req_ack_mode || ((req_bits != '0) && (req_bits <= BTOP)));
  assign bad_take  = req_valid && req_ready && !req_ack_mode &&
                     ((req_bits == '0) || (req_bits > BTOP));

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    good_take |=> !req_ready);

  p_reject_prompt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_take |=> (res_valid && res_reject));

  p_reject_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_reject) |-> ((res_word == '0) && !ack_found));

  p_result_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_reject) |-> !$past(req_ready));

  p_ack_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ack_found) |-> ((ack_windows != '0) && (ack_windows <= ATOP) && (res_word == '0)));
endmodule

bind sc_edge_rx sc_edge_rx_chk #(
  .MAX_BITS    (MAX_BITS),
  .ACK_MAX_WIN (ACK_MAX_WIN),
  .BITS_W      (BITS_W),
  .AW_W        (AW_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_ack_mode (req_ack_mode),
  .req_bits     (req_bits),
  .res_valid    (res_valid),
  .res_reject   (res_reject),
  .res_word     (res_word),
  .ack_found    (ack_found),
  .ack_windows  (ack_windows)
);

// File: tb/sc_edge_rx_bench.sv
`timescale 1ns/1ps
module sc_edge_rx_bench;
  localparam int TURN = 40;
  localparam int WIN  = 120;
  localparam int MAXB = 32;
  localparam int ACKN = 80;
  localparam int BW   = $clog2(MAXB + 1) + 1;
  localparam int AW   = $clog2(ACKN + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_ack_mode = 1'b0;
  logic [BW-1:0]   req_bits = '0;
  logic [MAXB-1:0] req_key = '0;
  logic            sc_in = 1'b0;
  logic            res_valid;
  logic            res_reject;
  logic [MAXB-1:0] res_word;
  logic            ack_found;
  logic [AW-1:0]   ack_windows;

  int checks = 0;
  int fails  = 0;
  int win_edges [0:79];

  always #2.5 clk = ~clk;

  sc_edge_rx #(
    .MAX_BITS(MAXB), .ACK_MAX_WIN(ACKN), .TURN_TICKS(TURN), .WIN_TICKS(WIN)
  ) u_sc_edge_rx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ack_mode(req_ack_mode), .req_bits(req_bits), .req_key(req_key),
    .sc_in(sc_in), .res_valid(res_valid), .res_reject(res_reject),
    .res_word(res_word), .ack_found(ack_found), .ack_windows(ack_windows)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int e);
    return (e > 63) ? 63 : e;
  endfunction

  task automatic run(input bit ack, input int nbits, input logic [31:0] key,
                     input int turn_edges, input string tag);
    logic [31:0] exp_word;
    bit exp_found;
    int exp_win;
    int nwin;
    bit rej;
    bit early;
    exp_word = '0; exp_found = 1'b0; exp_win = 0; nwin = 0; early = 1'b0;
    rej = !ack && (nbits == 0 || nbits > MAXB);
    if (!ack && !rej) begin
      for (int i = 0; i < nbits; i++) exp_word[i] = (sat(win_edges[i]) > 20) ^ key[i];
      nwin = nbits;
    end
    if (ack) begin
      exp_win = ACKN;
      for (int i = 0; i < ACKN; i++) begin
        if (!exp_found && sat(win_edges[i]) > 20 && sat(win_edges[i]) < 60) begin
          exp_found = 1'b1;
          exp_win = i + 1;
        end
      end
      nwin = exp_win;
    end
    @(negedge clk);
    chk({tag, " R1 ready while idle"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_ack_mode = ack; req_bits = BW'(nbits); req_key = key;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_key = $urandom; req_bits = BW'($urandom);
    if (rej) begin
      chk({tag, " R2 reject strobe"}, 32'(res_valid), 32'd1);
      chk({tag, " R2 reject flag"}, 32'(res_reject), 32'd1);
      chk({tag, " R2 reject word"}, res_word, 32'd0);
      chk({tag, " R2 reject ack"}, 32'(ack_found), 32'd0);
      return;
    end
    chk({tag, " R1 busy after take"}, 32'(req_ready), 32'd0);
    for (int k = 0; k < TURN + nwin * WIN; k++) begin
      int w;
      int j;
      if (k > 0) @(negedge clk);
      if (res_valid) early = 1'b1;
      if (k < TURN) begin
        if (k >= 5 && k - 5 < turn_edges) sc_in = ~sc_in;
      end else begin
        w = (k - TURN) / WIN;
        j = (k - TURN) % WIN;
        if (j >= 5 && j - 5 < win_edges[w]) sc_in = ~sc_in;
      end
    end
    @(negedge clk);
    chk({tag, " R4 no early result"}, 32'(early), 32'd0);
    chk({tag, " R4 result cycle"}, 32'(res_valid), 32'd1);
    chk({tag, " R2 no reject"}, 32'(res_reject), 32'd0);
    if (ack) begin
      chk({tag, " R8 R9 ack_found"}, 32'(ack_found), 32'(exp_found));
      chk({tag, " R8 R9 ack_windows"}, 32'(ack_windows), 32'(exp_win));
      chk({tag, " R8 word zero"}, res_word, 32'd0);
    end else begin
      chk({tag, " R5 R6 word"}, res_word, exp_word);
    end
    @(negedge clk);
    chk({tag, " R1 ready after result"}, 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    foreach (win_edges[i]) win_edges[i] = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R1 reset res_valid", 32'(res_valid), 32'd0);
    chk("R1 reset word", res_word, 32'd0);
    chk("R1 reset ack", 32'(ack_found), 32'd0);

    run(1'b0, 33, 32'hFFFF_FFFF, 0, "R2 len33");
    run(1'b0, 0, 32'h1234_5678, 0, "R2 len0");

    win_edges[0] = 0;  win_edges[1] = 21; win_edges[2] = 20; win_edges[3] = 42;
    win_edges[4] = 70; win_edges[5] = 5;  win_edges[6] = 63; win_edges[7] = 22;
    run(1'b0, 8, 32'h0, 30, "R3 R5 R7 directed");

    win_edges[0] = 0;
    run(1'b0, 1, 32'hFFFF_FFFF, 0, "R6 mask");

    for (int i = 0; i < 80; i++) win_edges[i] = 0;
    win_edges[0] = 21;
    run(1'b1, 0, 32'hDEAD_BEEF, 0, "R8 R10 first window");

    win_edges[0] = 0; win_edges[1] = 10; win_edges[2] = 70; win_edges[3] = 90;
    win_edges[4] = 60; win_edges[5] = 59;
    run(1'b1, 5, 32'h0, 25, "R7 R8 band");

    for (int i = 0; i < 80; i++) win_edges[i] = (i % 4 == 0) ? 20 : (i % 4 == 1) ? 0 : (i % 4 == 2) ? 60 : 95;
    run(1'b1, 3, 32'h0, 0, "R9 no ack");

    for (int n = 0; n < 12; n++) begin
      int nb;
      nb = (n == 0) ? 32 : $urandom_range(1, 32);
      for (int i = 0; i < 80; i++) win_edges[i] = $urandom_range(0, 100);
      run(1'b0, nb, $urandom, $urandom_range(0, 30), "R5 R6 random decode");
    end

    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 80; i++) begin
        if ($urandom_range(0, 19) == 0) win_edges[i] = $urandom_range(21, 59);
        else if ($urandom_range(0, 1) == 1) win_edges[i] = $urandom_range(0, 20);
        else win_edges[i] = $urandom_range(60, 100);
      end
      run(1'b1, $urandom_range(0, 40), $urandom, $urandom_range(0, 30), "R8 R9 random ack");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule